// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write an external asynchronous static RAM of 128K bytes. The host raises a request with a read/write flag, a 17-bit address and a write byte while `ready_o` is high. The controller then sequences the memory's active-low chip select, write strobe and output enable. It also drives the controller's half of a split data bus, which has separate out and in vectors and a driver enable for the pad. When the access completes, it returns a one-cycle `done_o` pulse, with the captured byte if the access was a read.

The length of each phase is a whole number of clocks. It is derived from a clock period parameter and nanosecond-class limits, all given in picoseconds. Each count is rounded up and never falls below one clock. The phases are address setup, write strobe width (the larger of pulse width and data setup), data hold, read access (the larger of address access and output-enable access), and a recovery phase that covers the memory's output turn-off time. With the default 8000 ps clock the counts are: setup 1, strobe 2, hold 1, access 2, recovery 1.

Memory control encoding: chip select low with output enable low and write strobe high makes the memory drive the bus. Chip select low with write strobe low writes. Chip select high deselects the memory.

Top module: `sram_async_ctl`

## Requirements
- R1: While `rst_ni` is low and after its release, `sram_cs_n_o`, `sram_we_n_o` and `sram_oe_n_o` are 1, `sram_dq_oe_o` is 0, `ready_o` is 1 and `done_o` is 0.
- R2: A write request accepted at edge E0 stores `wdata_i` at the full 17-bit `addr_i`; `done_o` is high in the cycle after edge E0+4 (default timing).
- R3: A read request accepted at edge E0 returns the stored byte on `rdata_o` with `done_o` high in the cycle after edge E0+2 (default timing), the byte being sampled from `sram_dq_i` only after the access count has elapsed.
- R4: During a write `sram_oe_n_o` stays 1, and `sram_dq_oe_o` is never 1 while the memory is enabled to drive (chip select and output enable both low).
- R5: The write strobe is low for exactly the rounded strobe count (2 clocks by default), and chip select is low during every cycle the strobe is low.
- R6: `sram_dq_o` is constant while the write strobe is low, `sram_dq_oe_o` is still 1 in the cycle after the strobe rises, and is 0 in the next cycle.
- R7: `ready_o` drops the cycle after a request is accepted and stays low through recovery; a request held or changed while `ready_o` is low starts no further memory access.
- R8: `sram_dq_oe_o` turns on only after output enable has been high for at least the rounded turnaround count (1 clock by default).
- R9: `sram_addr_o` does not change while chip select stays low.
- R10: `done_o` is a single-cycle pulse; `ready_o` returns in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled while ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Host byte address |
| wdata_i | input | 8 | Host write byte |
| ready_o | output | 1 | Controller idle, request may be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read byte, valid with done_o |
| sram_addr_o | output | 17 | Memory address |
| sram_cs_n_o | output | 1 | Memory chip select, active low |
| sram_we_n_o | output | 1 | Memory write strobe, active low |
| sram_oe_n_o | output | 1 | Memory output enable, active low |
| sram_dq_o | output | 8 | Data toward the memory |
| sram_dq_i | input | 8 | Data from the memory |
| sram_dq_oe_o | output | 1 | Enable for the controller's bus driver |

## Verification
The hardest situation to reach is a write that starts right after a read. In that case the memory's drivers may still be on while the controller wants to drive, and only the recovery count keeps the two apart. The bench issues back-to-back read and write pairs from its vector table and measures the idle gap between output enable rising and the driver enabling. Its memory model returns a poison byte until one access cycle has elapsed, so a read sampled too early shows up as a wrong byte. To cover the hold-off case, a request is kept high with a changed address and flag while the controller is busy, and the bench then confirms that no extra write strobe appeared.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_ACCESS,
    ST_RECOVER
  } st_e;

  // whole clocks covering t_ps, never less than one
  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          latch_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          drv_en_d_i,
  input  logic          capture_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      dq_oe_o <= drv_en_d_i;
      if (latch_i)   dq_o    <= wdata_i;
      if (capture_i) rdata_o <= dq_i;
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int CLK_PS    = 8000,
  parameter int T_AS_PS   = 0,
  parameter int T_WP_PS   = 12000,
  parameter int T_DW_PS   = 7000,
  parameter int T_DH_PS   = 0,
  parameter int T_AA_PS   = 15000,
  parameter int T_OE_PS   = 7000,
  parameter int T_HZ_PS   = 7000,
  parameter int T_WR_PS   = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_cs_n_o,
  output logic          sram_we_n_o,
  output logic          sram_oe_n_o,
  output logic [DW-1:0] sram_dq_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_dq_oe_o
);

  localparam int N_AS  = cyc_ceil(T_AS_PS, CLK_PS);
  localparam int N_WP  = imax(cyc_ceil(T_WP_PS, CLK_PS), cyc_ceil(T_DW_PS, CLK_PS));
  localparam int N_DH  = cyc_ceil(T_DH_PS, CLK_PS);
  localparam int N_RD  = imax(cyc_ceil(T_AA_PS, CLK_PS), cyc_ceil(T_OE_PS, CLK_PS));
  localparam int N_TA  = cyc_ceil(T_HZ_PS, CLK_PS);
  localparam int N_REC = imax(N_TA, cyc_ceil(T_WR_PS, CLK_PS));
  localparam int N_MAX = imax(imax(imax(N_AS, N_WP), imax(N_DH, N_RD)), N_REC);
  localparam int CW    = $clog2(N_MAX + 1);

  st_e           state_q, state_d;
  logic          t_load, t_expired;
  logic [CW-1:0] t_val;
  logic          accept, capture, drv_en_d;

  assign accept  = (state_q == ST_IDLE) && req_i;
  assign capture = (state_q == ST_ACCESS) && t_expired;

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = we_i ? ST_SETUP : ST_ACCESS;
        t_load  = 1'b1;
        t_val   = we_i ? CW'(N_AS - 1) : CW'(N_RD - 1);
      end
      ST_SETUP: if (t_expired) begin
        state_d = ST_PULSE;
        t_load  = 1'b1;
        t_val   = CW'(N_WP - 1);
      end
      ST_PULSE: if (t_expired) begin
        state_d = ST_HOLD;
        t_load  = 1'b1;
        t_val   = CW'(N_DH - 1);
      end
      ST_HOLD, ST_ACCESS: if (t_expired) begin
        state_d = ST_RECOVER;
        t_load  = 1'b1;
        t_val   = CW'(N_REC - 1);
      end
      ST_RECOVER: if (t_expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // pins are registered from the next state so they change cleanly with it
  assign drv_en_d = (state_d == ST_SETUP) || (state_d == ST_PULSE) || (state_d == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sram_cs_n_o <= 1'b1;
      sram_we_n_o <= 1'b1;
      sram_oe_n_o <= 1'b1;
      ready_o     <= 1'b1;
      done_o      <= 1'b0;
      sram_addr_o <= '0;
    end else begin
      state_q     <= state_d;
      sram_cs_n_o <= !(drv_en_d || (state_d == ST_ACCESS));
      sram_we_n_o <= (state_d != ST_PULSE);
      sram_oe_n_o <= (state_d != ST_ACCESS);
      ready_o     <= (state_d == ST_IDLE);
      done_o      <= (state_d == ST_RECOVER) && (state_q != ST_RECOVER);
      if (accept) sram_addr_o <= addr_i;
    end
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .expired_o  (t_expired)
  );

  sram_data_path #(.DW(DW)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .latch_i    (accept && we_i),
    .wdata_i    (wdata_i),
    .drv_en_d_i (drv_en_d),
    .capture_i  (capture),
    .dq_i       (sram_dq_i),
    .dq_o       (sram_dq_o),
    .dq_oe_o    (sram_dq_oe_o),
    .rdata_o    (rdata_o)
  );

  // window counters for the timing checks
  logic [CW-1:0] we_low_cnt_q, oe_high_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_cnt_q  <= '0;
      oe_high_cnt_q <= '0;
    end else begin
      if (sram_we_n_o)                     we_low_cnt_q <= '0;
      else if (we_low_cnt_q < CW'(N_MAX))  we_low_cnt_q <= we_low_cnt_q + 1'b1;
      if (!sram_oe_n_o)                    oe_high_cnt_q <= '0;
      else if (oe_high_cnt_q < CW'(N_MAX)) oe_high_cnt_q <= oe_high_cnt_q + 1'b1;
    end
  end

  assert_oe_off_while_driving_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_n_o);

  assert_strobe_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (we_low_cnt_q == CW'(N_WP)));

  assert_strobe_in_select_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> !sram_cs_n_o);

  assert_data_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_n_o && $past(!sram_we_n_o)) |-> $stable(sram_dq_o));

  assert_driver_after_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> sram_dq_oe_o);

  assert_busy_after_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i) |=> !ready_o);

  assert_turnaround_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (oe_high_cnt_q >= CW'(N_TA)));

  assert_addr_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_n_o && $past(!sram_cs_n_o)) |-> $stable(sram_addr_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));

endmodule

// File: tb/sram_async_ctl_tb.sv
module sram_async_ctl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, done;
  logic [7:0]  rdata;
  logic [16:0] s_addr;
  logic        cs_n, we_n, oe_n, dq_oe;
  logic [7:0]  dq_o, dq_i;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sram_async_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata), .sram_addr_o(s_addr),
    .sram_cs_n_o(cs_n), .sram_we_n_o(we_n), .sram_oe_n_o(oe_n),
    .sram_dq_o(dq_o), .sram_dq_i(dq_i), .sram_dq_oe_o(dq_oe)
  );

  // memory model: 256 bytes indexed by the low address byte
  logic [7:0]  mem [256];
  int          acc_cnt = 0;
  logic        mem_drives;
  assign mem_drives = !cs_n && !oe_n && we_n;
  assign dq_i = (mem_drives && acc_cnt >= 1) ? mem[s_addr[7:0]] : 8'hEE;

  always @(posedge clk) begin
    if (mem_drives) acc_cnt <= acc_cnt + 1; else acc_cnt <= 0;
    if (!cs_n && !we_n && dq_oe) mem[s_addr[7:0]] <= dq_o;
  end

  // port monitors, sampled at the falling edge
  int          wr_events = 0, contention = 0, addr_moves = 0, we_low = 0;
  int          bad_width = 0, bad_release = 0, bad_data = 0, oe_hi_run = 0, bad_ta = 0;
  logic        prev_we_n = 1'b1, prev_cs_n = 1'b1, prev_dq_oe = 1'b0, release_pending = 1'b0;
  logic [16:0] prev_addr = '0, last_wr_addr = '0;
  logic [7:0]  prev_dq = '0;

  always @(negedge clk) if (rst_n) begin
    if (dq_oe && mem_drives) contention++;
    if (!cs_n && !prev_cs_n && s_addr != prev_addr) addr_moves++;
    if (!we_n) begin
      if (cs_n || oe_n == 1'b0) bad_width++;
      if (!prev_we_n && dq_o != prev_dq) bad_data++;
      we_low++;
      last_wr_addr = s_addr;
    end
    if (we_n && !prev_we_n) begin
      wr_events++;
      if (we_low != 2) bad_width++;
      if (!dq_oe) bad_release++;
      release_pending = 1'b1;
      we_low = 0;
    end else if (release_pending) begin
      if (dq_oe) bad_release++;
      release_pending = 1'b0;
    end
    if (dq_oe && !prev_dq_oe && oe_hi_run < 1) bad_ta++;
    oe_hi_run = oe_n ? oe_hi_run + 1 : 0;
    prev_we_n = we_n; prev_cs_n = cs_n; prev_addr = s_addr; prev_dq = dq_o; prev_dq_oe = dq_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic w, input logic [16:0] a, input logic [7:0] d,
                           output logic [7:0] rd, output int lat, output int rlat,
                           output logic done_after);
    int k;
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    k = 1;
    while (!done && k < 40) begin @(negedge clk); k++; end
    lat = k; rd = rdata;
    @(negedge clk); k++;
    done_after = done;
    while (!ready && k < 40) begin @(negedge clk); k++; end
    rlat = k;
  endtask

  typedef struct packed {
    logic        w;
    logic [16:0] a;
    logic [7:0]  d;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 17'h00000, 8'hA5},
    '{1'b1, 17'h1FFFF, 8'h3C},
    '{1'b1, 17'h0AB12, 8'h7E},
    '{1'b0, 17'h00000, 8'hA5},
    '{1'b1, 17'h15555, 8'h00},
    '{1'b0, 17'h1FFFF, 8'h3C},
    '{1'b1, 17'h00000, 8'hFF},
    '{1'b0, 17'h0AB12, 8'h7E},
    '{1'b0, 17'h00000, 8'hFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lat, rlat, wr0;
    logic dn;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    repeat (3) @(negedge clk);
    chk(cs_n && we_n && oe_n && !dq_oe && ready && !done, "R1 in reset",
        {cs_n, we_n, oe_n, dq_oe, ready, done}, 6'b111010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && we_n && oe_n && !dq_oe && ready && !done, "R1 after release",
        {cs_n, we_n, oe_n, dq_oe, ready, done}, 6'b111010);

    for (int i = 0; i < NV; i++) begin
      do_access(VECS[i].w, VECS[i].a, VECS[i].d, rd, lat, rlat, dn);
      if (VECS[i].w) begin
        chk(lat == 5, "R2 write done latency", lat, 5);
        chk(mem[VECS[i].a[7:0]] == VECS[i].d, "R2 stored byte", mem[VECS[i].a[7:0]], VECS[i].d);
        chk(last_wr_addr == VECS[i].a, "R2 write address", last_wr_addr, VECS[i].a);
        chk(rlat == 6, "R10 ready after write", rlat, 6);
      end else begin
        chk(lat == 3, "R3 read done latency", lat, 3);
        chk(rd == VECS[i].d, "R3 read byte", rd, VECS[i].d);
        chk(rlat == 4, "R10 ready after read", rlat, 4);
      end
      chk(!dn, "R10 done single cycle", dn, 0);
    end

    // request held and changed while busy: must start nothing new
    wr0 = wr_events;
    req = 1'b1; we = 1'b0; addr = 17'h15555;
    @(negedge clk);
    chk(!ready, "R7 ready drops after accept", ready, 0);
    we = 1'b1; addr = 17'h15555; wdata = 8'h99;
    @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    chk(wr_events == wr0, "R7 no write while busy", wr_events - wr0, 0);
    do_access(1'b0, 17'h15555, 8'h00, rd, lat, rlat, dn);
    chk(rd == 8'h00, "R7 location untouched", rd, 8'h00);

    // read immediately followed by write to exercise bus turnaround
    do_access(1'b0, 17'h1FFFF, 8'h00, rd, lat, rlat, dn);
    do_access(1'b1, 17'h00042, 8'h5B, rd, lat, rlat, dn);
    chk(mem[8'h42] == 8'h5B, "R8 write after read stored", mem[8'h42], 8'h5B);

    chk(contention == 0, "R4 no bus contention, oe high in writes", contention, 0);
    chk(bad_width == 0, "R5 strobe width and select", bad_width, 0);
    chk(bad_data == 0 && bad_release == 0, "R6 data hold and release", bad_data + bad_release, 0);
    chk(bad_ta == 0, "R8 turnaround gap", bad_ta, 0);
    chk(addr_moves == 0, "R9 address stable", addr_moves, 0);

    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n && we_n && oe_n && !dq_oe && ready, "R1 mid-run reset",
        {cs_n, we_n, oe_n, dq_oe, ready}, 5'b11101);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule